// File: doc/BRIEF.md
# MSI Capture and Interrupt Controller

This block watches the stream of inbound memory writes arriving from the link side of a host bridge. It recognises message-signalled interrupts and turns them into pending bits, and it raises one interrupt line toward the processor. A write counts as an interrupt message when three things hold: capture is enabled, the write lands on the programmed 64-bit target address, and its data passes a masked pattern compare. The low data bits of such a write then pick one of 32 vectors. Every other write leaves the block unchanged on a forwarding port one cycle later.

Software programs the block through a small word-indexed register port. That port holds the target address, with the capture enable folded into bit 0 of the low word. A single data-configuration word holds the compare mask in its upper half and the expected pattern in its lower half. The usual setting is 0xffe06540: the sender then puts 0x6540 plus the vector number in the data. Pending bits are cleared by writing ones. Vectors are masked or unmasked by writing ones to separate set and clear registers.

Top module: `msi_capture_ctrl`

## Requirements
- R1: After reset, all pending bits are 0, all 32 vectors are masked, the capture enable and target address are 0, and irq is 0.
- R2: An inbound write is captured when the enable (bit 0 of register index 4) is 1 and the write address matches {index 5, index 4} with bit 0 of both ignored. Pending bit data[4:0] is then set at the next clock edge.
- R3: The data-configuration word (index 6) gives a mask in bits [31:16] and a pattern in bits [15:0]. A write matches only if (data[15:0] & mask) equals (pattern & mask). Data bits [31:16] never affect the match.
- R4: A write that fails the address or data test, or that arrives while the enable is 0, changes no pending bit. It appears on fwd_valid/fwd_addr/fwd_data one cycle later.
- R5: A captured write is not forwarded: fwd_valid stays 0 in the following cycle.
- R6: Writing ones to the clear register (index 1) clears those pending bits. Bits written as zero keep their value, and pending bits fall only through this register.
- R7: Writing ones to mask-set (index 2) masks those vectors. Writing ones to mask-clear (index 3) unmasks them. Both indices read back the current mask, with 1 meaning masked.
- R8: irq is a register equal to the OR of (pending & ~mask), updated on the same edge as the pending and mask bits. A masked vector still latches its pending bit.
- R9: When a capture and a clear of the same pending bit occur in the same cycle, the bit ends up set.
- R10: reg_rdata shows the register selected by reg_addr one cycle later. Index 0 reads the pending bits, index 1 reads 0, and indices 4, 5 and 6 read back the value written, including the enable bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 3 | Register word index |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Registered read data for reg_addr |
| in_valid | input | 1 | Inbound memory write valid |
| in_addr | input | 64 | Inbound write address |
| in_data | input | 32 | Inbound write data |
| fwd_valid | output | 1 | Forwarded (non-captured) write valid |
| fwd_addr | output | 64 | Forwarded write address |
| fwd_data | output | 32 | Forwarded write data |
| irq | output | 1 | Interrupt request |

## Verification
The hardest case to reach from the ports is an inbound capture and a software clear of the same pending bit landing on one clock edge. This depends on two unrelated interfaces lining up exactly. The bench drives both from one task: the register write and the inbound write are set up on the same falling edge, and the result is read back afterwards. The other cases that need care are a target address whose bit 0 is set, data whose upper half is random, and a vector that is masked yet latched. Each of these is checked through readback and the irq pin.

// File: rtl/msi_cap_pkg.sv
package msi_cap_pkg;
  localparam int REG_W  = 32;
  localparam int RIDX_W = 3;

  typedef enum logic [RIDX_W-1:0] {
    RG_PEND  = 3'd0,
    RG_CLEAR = 3'd1,
    RG_MSET  = 3'd2,
    RG_MCLR  = 3'd3,
    RG_TLO   = 3'd4,
    RG_THI   = 3'd5,
    RG_DCFG  = 3'd6
  } reg_sel_e;
endpackage

// File: rtl/msi_cfg_regs.sv
module msi_cfg_regs
  import msi_cap_pkg::*;
#(
  parameter int ADDR_W = 64
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              reg_we,
  input  logic [RIDX_W-1:0] reg_addr,
  input  logic [REG_W-1:0]  reg_wdata,
  output logic              cap_en,
  output logic [ADDR_W-1:1] tgt_addr,
  output logic [15:0]       cmp_mask,
  output logic [15:0]       cmp_pat,
  output logic [REG_W-1:0]  tlo_q,
  output logic [REG_W-1:0]  thi_q,
  output logic [REG_W-1:0]  dcfg_q
);
  logic [2*REG_W-1:0] tgt_full;

  always_ff @(posedge clk) begin
    if (rst) begin
      tlo_q  <= '0;
      thi_q  <= '0;
      dcfg_q <= '0;
    end else if (reg_we) begin
      case (reg_sel_e'(reg_addr))
        RG_TLO:  tlo_q  <= reg_wdata;
        RG_THI:  thi_q  <= reg_wdata;
        RG_DCFG: dcfg_q <= reg_wdata;
        default: ;
      endcase
    end
  end

  assign tgt_full = {thi_q, tlo_q};
  assign tgt_addr = tgt_full[ADDR_W-1:1];
  assign cap_en   = tlo_q[0];
  assign cmp_mask = dcfg_q[31:16];
  assign cmp_pat  = dcfg_q[15:0];
endmodule

// File: rtl/msi_match.sv
module msi_match #(
  parameter int ADDR_W = 64,
  parameter int VEC_W  = 5
) (
  input  logic              in_valid,
  input  logic [ADDR_W-1:0] in_addr,
  input  logic [15:0]       in_data_lo,
  input  logic              cap_en,
  input  logic [ADDR_W-1:1] tgt_addr,
  input  logic [15:0]       cmp_mask,
  input  logic [15:0]       cmp_pat,
  output logic              hit,
  output logic [VEC_W-1:0]  hit_vec
);
  logic addr_ok;
  logic data_ok;

  assign addr_ok = (in_addr | ADDR_W'(1)) == {tgt_addr, 1'b1};
  assign data_ok = ((in_data_lo ^ cmp_pat) & cmp_mask) == 16'h0;
  assign hit     = in_valid && cap_en && addr_ok && data_ok;
  assign hit_vec = in_data_lo[VEC_W-1:0];
endmodule

// File: rtl/msi_pending.sv
module msi_pending #(
  parameter int NUM_VEC = 32,
  parameter int VEC_W   = 5
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               hit,
  input  logic [VEC_W-1:0]   hit_vec,
  input  logic [NUM_VEC-1:0] clr_bits,
  input  logic [NUM_VEC-1:0] mset_bits,
  input  logic [NUM_VEC-1:0] mclr_bits,
  output logic [NUM_VEC-1:0] status_q,
  output logic [NUM_VEC-1:0] mask_q,
  output logic               irq_q
);
  logic [NUM_VEC-1:0] set_bits;
  logic [NUM_VEC-1:0] status_d;
  logic [NUM_VEC-1:0] mask_d;

  always_comb begin
    set_bits = '0;
    if (hit) set_bits = NUM_VEC'(1) << hit_vec;
    status_d = (status_q & ~clr_bits) | set_bits;
    mask_d   = (mask_q | mset_bits) & ~mclr_bits;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      status_q <= '0;
      mask_q   <= '1;
      irq_q    <= 1'b0;
    end else begin
      status_q <= status_d;
      mask_q   <= mask_d;
      irq_q    <= |(status_d & ~mask_d);
    end
  end
endmodule

// File: rtl/msi_capture_ctrl.sv
module msi_capture_ctrl
  import msi_cap_pkg::*;
#(
  parameter int NUM_VEC = 32,
  parameter int ADDR_W  = 64,
  parameter int DATA_W  = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              reg_we,
  input  logic [2:0]        reg_addr,
  input  logic [31:0]       reg_wdata,
  output logic [31:0]       reg_rdata,
  input  logic              in_valid,
  input  logic [63:0]       in_addr,
  input  logic [31:0]       in_data,
  output logic              fwd_valid,
  output logic [63:0]       fwd_addr,
  output logic [31:0]       fwd_data,
  output logic              irq
);
  localparam int VEC_W = $clog2(NUM_VEC);

  logic               cap_en;
  logic [ADDR_W-1:1]  tgt_addr;
  logic [15:0]        cmp_mask;
  logic [15:0]        cmp_pat;
  logic [REG_W-1:0]   tlo_q, thi_q, dcfg_q;
  logic               hit;
  logic [VEC_W-1:0]   hit_vec;
  logic [NUM_VEC-1:0] clr_bits, mset_bits, mclr_bits;
  logic [NUM_VEC-1:0] status_q, mask_q;
  logic               irq_q;
  logic [REG_W-1:0]   rd_mux;

  msi_cfg_regs #(.ADDR_W(ADDR_W)) u_cfg (
    .clk(clk), .rst(rst), .reg_we(reg_we), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .cap_en(cap_en), .tgt_addr(tgt_addr),
    .cmp_mask(cmp_mask), .cmp_pat(cmp_pat),
    .tlo_q(tlo_q), .thi_q(thi_q), .dcfg_q(dcfg_q)
  );

  msi_match #(.ADDR_W(ADDR_W), .VEC_W(VEC_W)) u_match (
    .in_valid(in_valid), .in_addr(in_addr[ADDR_W-1:0]),
    .in_data_lo(in_data[15:0]), .cap_en(cap_en), .tgt_addr(tgt_addr),
    .cmp_mask(cmp_mask), .cmp_pat(cmp_pat), .hit(hit), .hit_vec(hit_vec)
  );

  always_comb begin
    clr_bits  = '0;
    mset_bits = '0;
    mclr_bits = '0;
    if (reg_we) begin
      case (reg_sel_e'(reg_addr))
        RG_CLEAR: clr_bits  = reg_wdata[NUM_VEC-1:0];
        RG_MSET:  mset_bits = reg_wdata[NUM_VEC-1:0];
        RG_MCLR:  mclr_bits = reg_wdata[NUM_VEC-1:0];
        default: ;
      endcase
    end
  end

  msi_pending #(.NUM_VEC(NUM_VEC), .VEC_W(VEC_W)) u_pend (
    .clk(clk), .rst(rst), .hit(hit), .hit_vec(hit_vec),
    .clr_bits(clr_bits), .mset_bits(mset_bits), .mclr_bits(mclr_bits),
    .status_q(status_q), .mask_q(mask_q), .irq_q(irq_q)
  );

  always_comb begin
    case (reg_sel_e'(reg_addr))
      RG_PEND:         rd_mux = REG_W'(status_q);
      RG_MSET, RG_MCLR: rd_mux = REG_W'(mask_q);
      RG_TLO:          rd_mux = tlo_q;
      RG_THI:          rd_mux = thi_q;
      RG_DCFG:         rd_mux = dcfg_q;
      default:         rd_mux = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      reg_rdata <= '0;
      fwd_valid <= 1'b0;
      fwd_addr  <= '0;
      fwd_data  <= '0;
    end else begin
      reg_rdata <= rd_mux;
      fwd_valid <= in_valid && !hit;
      if (in_valid && !hit) begin
        fwd_addr <= in_addr;
        fwd_data <= in_data;
      end
    end
  end

  assign irq = irq_q;
endmodule

// File: rtl/msi_capture_ctrl_chk.sv
module msi_capture_ctrl_chk
  import msi_cap_pkg::*;
#(
  parameter int NUM_VEC = 32,
  parameter int VEC_W   = 5
) (
  input logic               clk,
  input logic               rst,
  input logic               reg_we,
  input logic [2:0]         reg_addr,
  input logic               in_valid,
  input logic               hit,
  input logic [VEC_W-1:0]   hit_vec,
  input logic [NUM_VEC-1:0] status_q,
  input logic [NUM_VEC-1:0] mask_q,
  input logic               fwd_valid,
  input logic               irq
);
  // R1: state right after reset release
  p_reset_state_r1: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (status_q == '0 && mask_q == '1 && !irq));

  // R2 and R9: a capture always leaves its bit set, even with a clear
  p_capture_sets_r2: assert property (@(posedge clk) disable iff (rst)
    $past(hit) |-> status_q[$past(hit_vec)]);

  // R5: captured write is not forwarded
  p_no_fwd_on_hit_r5: assert property (@(posedge clk) disable iff (rst)
    $past(hit) |-> !fwd_valid);

  // R4: forwarding only follows an inbound write
  p_fwd_needs_write_r4: assert property (@(posedge clk) disable iff (rst)
    fwd_valid |-> $past(in_valid));

  // R6: pending bits fall only through the clear register
  p_pend_fall_r6: assert property (@(posedge clk) disable iff (rst)
    (|($past(status_q) & ~status_q)) |-> $past(reg_we && reg_addr == RG_CLEAR));

  // R7: mask bits fall only through the mask-clear register
  p_mask_fall_r7: assert property (@(posedge clk) disable iff (rst)
    (|($past(mask_q) & ~mask_q)) |-> $past(reg_we && reg_addr == RG_MCLR));

  // R8: irq tracks unmasked pending bits
  p_irq_track_r8: assert property (@(posedge clk) disable iff (rst)
    irq == (|(status_q & ~mask_q)));
endmodule

bind msi_capture_ctrl msi_capture_ctrl_chk #(.NUM_VEC(NUM_VEC), .VEC_W(VEC_W)) u_chk (
  .clk(clk), .rst(rst), .reg_we(reg_we), .reg_addr(reg_addr),
  .in_valid(in_valid), .hit(hit), .hit_vec(hit_vec),
  .status_q(status_q), .mask_q(mask_q), .fwd_valid(fwd_valid), .irq(irq)
);

// File: tb/msi_capture_ctrl_test.sv
`timescale 1ns/1ps
module msi_capture_ctrl_test;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        reg_we = 1'b0;
  logic [2:0]  reg_addr = '0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic        in_valid = 1'b0;
  logic [63:0] in_addr = '0;
  logic [31:0] in_data = '0;
  logic        fwd_valid;
  logic [63:0] fwd_addr;
  logic [31:0] fwd_data;
  logic        irq;

  int checks = 0;
  int errors = 0;
  int cycles = 0;
  logic [31:0] exp_pend = '0;
  logic [31:0] exp_mask = '1;
  logic        got_fv;
  logic [63:0] got_fa;
  logic [31:0] got_fd;

  localparam logic [63:0] TGT = 64'h0000_0001_0000_1000;

  always #5 clk = ~clk;

  msi_capture_ctrl uut (
    .clk(clk), .rst(rst), .reg_we(reg_we), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .in_valid(in_valid),
    .in_addr(in_addr), .in_data(in_data), .fwd_valid(fwd_valid),
    .fwd_addr(fwd_addr), .fwd_data(fwd_data), .irq(irq)
  );

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  task automatic summary();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 100000) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual %0d expected below 100000", cycles);
      summary();
    end
  end

  task automatic reg_wr(input logic [2:0] a, input logic [31:0] d);
    @(negedge clk);
    reg_we = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_we = 1'b0;
  endtask

  task automatic reg_rd(input logic [2:0] a, output logic [31:0] v);
    @(negedge clk);
    reg_addr = a;
    @(negedge clk);
    v = reg_rdata;
  endtask

  task automatic send(input logic [63:0] a, input logic [31:0] d);
    @(negedge clk);
    in_valid = 1'b1; in_addr = a; in_data = d;
    @(negedge clk);
    got_fv = fwd_valid; got_fa = fwd_addr; got_fd = fwd_data;
    in_valid = 1'b0;
  endtask

  task automatic check_pend(input string req);
    logic [31:0] v;
    reg_rd(3'd0, v);
    chk(req, v, exp_pend);
  endtask

  task automatic t_reset();
    logic [31:0] v;
    reg_rd(3'd0, v); chk("R1 pending", v, 32'h0);
    reg_rd(3'd2, v); chk("R1 mask", v, 32'hFFFF_FFFF);
    reg_rd(3'd4, v); chk("R1 target/enable", v, 32'h0);
    chk("R1 irq", irq, 1'b0);
  endtask

  task automatic t_config();
    logic [31:0] v;
    reg_wr(3'd4, TGT[31:0] | 32'h1);
    reg_wr(3'd5, TGT[63:32]);
    reg_wr(3'd6, 32'hFFE0_6540);
    reg_rd(3'd4, v); chk("R10 target low with enable", v, 32'h0000_1001);
    reg_rd(3'd5, v); chk("R10 target high", v, 32'h1);
    reg_rd(3'd6, v); chk("R10 data config", v, 32'hFFE0_6540);
    reg_rd(3'd1, v); chk("R10 clear reads zero", v, 32'h0);
  endtask

  task automatic t_capture_masked();
    send(TGT, 32'h0000_6545);
    exp_pend[5] = 1'b1;
    chk("R5 no forward on capture", got_fv, 1'b0);
    chk("R8 masked vector gives no irq", irq, 1'b0);
    check_pend("R2 vector 5 latched while masked");
  endtask

  task automatic t_unmask();
    logic [31:0] v;
    reg_wr(3'd3, 32'h0000_0020);
    exp_mask[5] = 1'b0;
    chk("R8 irq after unmask", irq, 1'b1);
    reg_rd(3'd3, v); chk("R7 mask after mask-clear", v, exp_mask);
  endtask

  task automatic t_bit0_and_top_vec();
    send(TGT | 64'h1, 32'h0000_655F);
    exp_pend[31] = 1'b1;
    check_pend("R2 address bit 0 ignored, vector 31");
  endtask

  task automatic t_data_mismatch();
    send(TGT, 32'h0000_6560);
    chk("R3 pattern mismatch forwarded", got_fv, 1'b1);
    chk("R4 forwarded data", got_fd, 32'h0000_6560);
    check_pend("R3 mismatch leaves pending");
    send(TGT, 32'hABCD_6540);
    exp_pend[0] = 1'b1;
    chk("R3 upper data ignored, not forwarded", got_fv, 1'b0);
    check_pend("R3 upper data ignored, vector 0");
  endtask

  task automatic t_addr_mismatch();
    send(TGT + 64'h4, 32'h0000_6543);
    chk("R4 address mismatch forwarded", got_fv, 1'b1);
    chk("R4 forwarded address", got_fa, TGT + 64'h4);
    check_pend("R4 address mismatch no capture");
  endtask

  task automatic t_clear();
    reg_wr(3'd1, 32'h0000_0020);
    exp_pend[5] = 1'b0;
    check_pend("R6 write-one clear keeps others");
    chk("R8 irq drops after clear", irq, 1'b0);
  endtask

  task automatic t_mask_set();
    logic [31:0] v;
    reg_wr(3'd3, 32'h8000_0000);
    exp_mask[31] = 1'b0;
    chk("R7 irq after unmasking 31", irq, 1'b1);
    reg_wr(3'd2, 32'h8000_0000);
    exp_mask[31] = 1'b1;
    chk("R7 irq after mask-set", irq, 1'b0);
    reg_rd(3'd2, v); chk("R7 mask readback", v, exp_mask);
  endtask

  task automatic t_disabled();
    reg_wr(3'd4, TGT[31:0]);
    send(TGT, 32'h0000_6549);
    chk("R4 disabled write forwarded", got_fv, 1'b1);
    check_pend("R4 disabled no capture");
    reg_wr(3'd4, TGT[31:0] | 32'h1);
  endtask

  task automatic t_collide();
    @(negedge clk);
    in_valid = 1'b1; in_addr = TGT; in_data = 32'h0000_6547;
    reg_we = 1'b1; reg_addr = 3'd1; reg_wdata = 32'h0000_0081;
    @(negedge clk);
    in_valid = 1'b0; reg_we = 1'b0;
    exp_pend[7] = 1'b1;
    exp_pend[0] = 1'b0;
    check_pend("R9 capture wins over same-cycle clear");
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    t_reset();
    t_config();
    t_capture_masked();
    t_unmask();
    t_bit0_and_top_vec();
    t_data_mismatch();
    t_addr_mismatch();
    t_clear();
    t_mask_set();
    t_disabled();
    t_collide();
    repeat (2) @(negedge clk);
    summary();
  end
endmodule